// File: doc/BRIEF.md
# Mode Register Unlock Sequence Detector

This block sits beside the array controller of a pseudo-static RAM and watches every bus cycle that reaches it. The mode register holds the partial-refresh retention size and the page-read length. Software reaches this register only through the ordinary read/write interface, by sending a four-step sequence aimed at the highest word address. Two reads come first, and each must show both chip select and output enable toggled. Then two writes follow, each with chip select toggled: an all-zero word, and then the setting word. When the last step matches, the register loads and a valid flag sets. While the two command writes are accepted, a same-cycle blocking signal keeps them out of the array, so they never land in storage.

Each bus cycle arrives as a single-cycle read or write strobe with its address, write data and two toggle flags. There is no back-pressure: every strobe is consumed in the cycle it appears, and cycles with no strobe do not advance or abort a sequence. If an access does not match the expected next step, the attempt ends and the detector returns to idle. That access is not blocked. A fresh attempt may begin only if the access before it went to some other address, or if no access has occurred since reset. As a result, three top-address reads in a row defeat the sequence.

Top module: `mreg_seq_detect`

## Requirements
- R1: After reset, mode_valid, mode_density, mode_page8 and cmd_block are all 0.
- R2: A complete sequence loads the mode register from the last write's data. Bits [1:0] give mode_density (00 = largest retention, 01, 10, 11 = nothing retained) and bit 2 gives mode_page8. mode_valid is set. The new values appear on the outputs in the cycle after the last write strobe.
- R3: cmd_block is 1 in the same cycle as the third and the fourth strobes of a matching sequence and 0 for every read and every other write.
- R4: Any step without cs_toggled, or either read step without oe_toggled, aborts the attempt.
- R5: The fourth step is accepted only when its data is 0x0004 to 0x0007, with every bit above bit 2 zero. Any other value aborts, is not blocked and leaves the register unchanged.
- R6: The third step is accepted only when its data is all zeros. Otherwise it aborts and is not blocked.
- R7: An access to another address during a sequence, or an access in the wrong order (a write where a read is due, or the reverse), aborts. The mode outputs stay unchanged and the aborting access is not blocked.
- R8: A third consecutive read of the top address aborts the attempt. Further sequences fail until an access is made to a different address.
- R9: A sequence may start only if no access has occurred since reset or the previous access (read or write) used an address other than the top. This includes the case right after a successful programming.
- R10: Once valid, the mode register keeps its value through any traffic that is not a complete sequence. A later complete sequence replaces it.
- R11: Clock cycles with neither strobe, placed between steps, neither advance nor abort a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| rd_stb | input | 1 | One bus read cycle this clock |
| wr_stb | input | 1 | One bus write cycle this clock (never together with rd_stb) |
| addr | input | ADDR_W | Word address of the cycle |
| wdata | input | DATA_W | Write data of the cycle |
| cs_toggled | input | 1 | Chip select went inactive and active again around this cycle |
| oe_toggled | input | 1 | Output enable went inactive and active again around this cycle |
| cmd_block | output | 1 | Suppress this write at the array: it is an accepted command write |
| mode_density | output | 2 | Retention size field of the mode register |
| mode_page8 | output | 1 | Page-length field of the mode register (1 = eight-word page) |
| mode_valid | output | 1 | Mode register has been programmed since reset |

## Verification
The bench sweeps every possible final data byte and every possible second-write byte on a 4-bit-address, 8-bit-data build. A decoder that ignored the upper bits or the page bit would then accept values such as 0x84 or 0x03 and corrupt the register. It places every non-top address, and each missing toggle flag, at each of the four steps. A detector that failed to abort would block an access that should pass through, or would load the register. It reads the top address three times, retries straight after a success, and uses reversed order. A design without the re-arm rule would accept the retries and program the register. Spaced steps and non-top traffic check that idle cycles and ordinary accesses neither advance a sequence nor disturb a stored setting.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD1  = 2'd1,
    SEQ_RD2  = 2'd2,
    SEQ_WR1  = 2'd3
  } seq_state_t;

  localparam int DENS_W = 2;
  localparam int SET_W  = DENS_W + 1;

  typedef struct packed {
    logic              page8;
    logic [DENS_W-1:0] density;
  } mode_t;

endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              top_hit,
  output logic              data_zero,
  output logic              setting_ok,
  output mode_t             setting
);

  logic upper_zero;

  assign top_hit   = &addr;
  assign data_zero = ~|wdata;

  generate
    if (DATA_W > SET_W) begin : g_upper
      assign upper_zero = ~|wdata[DATA_W-1:SET_W];
    end else begin : g_exact
      assign upper_zero = 1'b1;
    end
  endgenerate

  // the page bit must be set; the density field takes all four codes
  assign setting    = mode_t'(wdata[SET_W-1:0]);
  assign setting_ok = upper_zero & setting.page8;

endmodule

// File: rtl/mrs_seq_fsm.sv
module mrs_seq_fsm
  import mrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic cs_toggled,
  input  logic oe_toggled,
  input  logic top_hit,
  input  logic data_zero,
  input  logic setting_ok,
  output logic load,
  output logic cmd_block
);

  seq_state_t state_q, state_d;
  logic armed_q, armed_d;
  logic any_acc, rd_step, wr_zero_step, wr_set_step;

  assign any_acc      = rd_stb | wr_stb;
  assign rd_step      = rd_stb & top_hit & cs_toggled & oe_toggled;
  assign wr_zero_step = wr_stb & top_hit & cs_toggled & data_zero;
  assign wr_set_step  = wr_stb & top_hit & cs_toggled & setting_ok;

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    cmd_block = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (rd_step && armed_q) state_d = SEQ_RD1;
      end
      SEQ_RD1: begin
        if (rd_step)      state_d = SEQ_RD2;
        else if (any_acc) state_d = SEQ_IDLE;
      end
      SEQ_RD2: begin
        if (wr_zero_step) begin
          state_d   = SEQ_WR1;
          cmd_block = 1'b1;
        end else if (any_acc) begin
          state_d = SEQ_IDLE;
        end
      end
      SEQ_WR1: begin
        if (wr_set_step) begin
          state_d   = SEQ_IDLE;
          load      = 1'b1;
          cmd_block = 1'b1;
        end else if (any_acc) begin
          state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // re-arm only after touching a different address
  always_comb begin
    armed_d = armed_q;
    if (any_acc) armed_d = ~top_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      armed_q <= 1'b1;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  AST_NO_START_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && !armed_q) |=> (state_q != SEQ_RD1)); // R8

  AST_TOP_ACCESS_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && top_hit) |=> !armed_q); // R9

  AST_WR1_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WR1) |-> ($past(state_q) == SEQ_RD2 || $past(state_q) == SEQ_WR1)); // R7

endmodule

// File: rtl/mrs_mode_reg.sv
module mrs_mode_reg
  import mrs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  mode_t setting,
  output mode_t mode_q,
  output logic  valid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      mode_q  <= setting;
      valid_q <= 1'b1;
    end
  end

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode_q)); // R10

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q); // R10

endmodule

// File: rtl/mreg_seq_detect.sv
module mreg_seq_detect
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cs_toggled,
  input  logic              oe_toggled,
  output logic              cmd_block,
  output logic [1:0]        mode_density,
  output logic              mode_page8,
  output logic              mode_valid
);

  logic  top_hit, data_zero, setting_ok, load;
  mode_t setting, mode_q;

  mrs_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr       (addr),
    .wdata      (wdata),
    .top_hit    (top_hit),
    .data_zero  (data_zero),
    .setting_ok (setting_ok),
    .setting    (setting)
  );

  mrs_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .cs_toggled (cs_toggled),
    .oe_toggled (oe_toggled),
    .top_hit    (top_hit),
    .data_zero  (data_zero),
    .setting_ok (setting_ok),
    .load       (load),
    .cmd_block  (cmd_block)
  );

  mrs_mode_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .setting (setting),
    .mode_q  (mode_q),
    .valid_q (mode_valid)
  );

  assign mode_density = mode_q.density;
  assign mode_page8   = mode_q.page8;

  AST_VALID_RISE_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_valid) |-> $past(cmd_block)); // R2

  AST_BLOCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_block |-> (cs_toggled && wr_stb)); // R4

endmodule

// File: tb/sim_mreg_seq_detect.sv
module sim_mreg_seq_detect;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] TOP = '1;
  localparam logic [3:0][AW-1:0] TOPS = {TOP, TOP, TOP, TOP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb = 1'b0, wr_stb = 1'b0, cs_t = 1'b0, oe_t = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic cmd_block, mode_page8, mode_valid;
  logic [1:0] mode_density;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [1:0] exp_dens = 2'd0;
  logic exp_page = 1'b0, exp_valid = 1'b0;

  always #2.5 clk = ~clk;

  mreg_seq_detect #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(addr), .wdata(wdata), .cs_toggled(cs_t), .oe_toggled(oe_t),
    .cmd_block(cmd_block), .mode_density(mode_density),
    .mode_page8(mode_page8), .mode_valid(mode_valid)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input bit cs, input bit oe, output bit b);
    @(negedge clk);
    rd_stb = !wr; wr_stb = wr; addr = a; wdata = d; cs_t = cs; oe_t = oe;
    #1 b = cmd_block;
    @(posedge clk);
    #1 rd_stb = 0; wr_stb = 0; cs_t = 0; oe_t = 0;
  endtask

  task automatic run_seq(input logic [3:0][AW-1:0] ads, input logic [DW-1:0] d2, input logic [DW-1:0] d3,
                         input bit [3:0] csm, input bit [1:0] oem, output bit [3:0] bl);
    acc(1'b0, ads[0], '0, csm[0], oem[0], bl[0]);
    acc(1'b0, ads[1], '0, csm[1], oem[1], bl[1]);
    acc(1'b1, ads[2], d2, csm[2], 1'b1, bl[2]);
    acc(1'b1, ads[3], d3, csm[3], 1'b1, bl[3]);
  endtask

  task automatic prime(input logic [AW-1:0] a);
    bit b;
    acc(1'b0, a, '0, 1'b1, 1'b1, b);
  endtask

  task automatic check_mode(input string req);
    @(negedge clk);
    chk(req, "mode_valid", mode_valid, exp_valid);
    chk(req, "mode_density", mode_density, exp_dens);
    chk(req, "mode_page8", mode_page8, exp_page);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit [3:0] bl;
    bit b;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "cmd_block", cmd_block, 0);
    chk("R1", "mode_valid", mode_valid, 0);
    chk("R1", "mode_density", mode_density, 0);
    chk("R1", "mode_page8", mode_page8, 0);
    @(negedge clk) rst_n = 1'b1;
    check_mode("R1");

    // R2 R3 R5: every final data byte
    for (int d = 0; d < 256; d++) begin
      bit ok;
      ok = (d >= 4 && d <= 7);
      prime('0);
      run_seq(TOPS, 8'h00, d[7:0], 4'hF, 2'b11, bl);
      chk("R3", "read blk", {bl[1], bl[0]}, 0);
      chk("R3", "zero write blk", bl[2], 1);
      chk(ok ? "R2" : "R5", "final write blk", bl[3], ok);
      if (ok) begin
        exp_valid = 1'b1; exp_dens = d[1:0]; exp_page = d[2];
      end
      check_mode(ok ? "R2" : "R5");
    end

    // R6: every nonzero second-write byte
    for (int d = 1; d < 256; d++) begin
      prime('0);
      run_seq(TOPS, d[7:0], 8'h05, 4'hF, 2'b11, bl);
      chk("R6", "blk", bl, 0);
      check_mode("R6");
    end

    // R7: a foreign address at each step
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 15; a++) begin
        logic [3:0][AW-1:0] ads;
        ads = TOPS;
        ads[k] = a[AW-1:0];
        prime('0);
        run_seq(ads, 8'h00, 8'h04, 4'hF, 2'b11, bl);
        chk("R7", "blk", bl, (k == 3) ? 4'b0100 : 4'b0000);
        check_mode("R7");
      end
    end

    // R4: missing toggles at each step
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < ((k < 2) ? 3 : 1); v++) begin
        bit [3:0] csm;
        bit [1:0] oem;
        csm = 4'hF; oem = 2'b11;
        if (v != 1) csm[k] = 1'b0;
        if (v != 0) oem[k] = 1'b0;
        prime('0);
        run_seq(TOPS, 8'h00, 8'h04, csm, oem, bl);
        chk("R4", "blk", bl, (k == 3) ? 4'b0100 : 4'b0000);
        check_mode("R4");
      end
    end

    // R7: wrong order
    prime('0);
    acc(1'b0, TOP, '0, 1, 1, bl[0]);
    acc(1'b1, TOP, 8'h00, 1, 1, bl[1]);
    acc(1'b0, TOP, '0, 1, 1, bl[2]);
    acc(1'b1, TOP, 8'h04, 1, 1, bl[3]);
    chk("R7", "order blk", bl, 0);
    check_mode("R7");

    // R8: three top reads
    prime('0);
    acc(1'b0, TOP, '0, 1, 1, b);
    run_seq(TOPS, 8'h00, 8'h04, 4'hF, 2'b11, bl);
    chk("R8", "triple read blk", bl, 0);
    run_seq(TOPS, 8'h00, 8'h04, 4'hF, 2'b11, bl);
    chk("R8", "no re-arm blk", bl, 0);
    check_mode("R8");
    prime(4'h3);
    run_seq(TOPS, 8'h00, 8'h05, 4'hF, 2'b11, bl);
    chk("R8", "re-armed blk", bl, 4'b1100);
    exp_dens = 2'd1; exp_page = 1'b1;
    check_mode("R8");

    // R9: retry right after success, then re-arm by a write elsewhere
    run_seq(TOPS, 8'h00, 8'h06, 4'hF, 2'b11, bl);
    chk("R9", "retry blk", bl, 0);
    check_mode("R9");
    acc(1'b1, 4'h2, 8'hAA, 1, 0, b);
    chk("R9", "plain write blk", b, 0);
    run_seq(TOPS, 8'h00, 8'h06, 4'hF, 2'b11, bl);
    chk("R9", "after write blk", bl, 4'b1100);
    exp_dens = 2'd2;
    check_mode("R9");

    // R10: ordinary traffic keeps the register
    for (int a = 0; a < 15; a++) begin
      acc(a[0], a[AW-1:0], 8'h04, 1, 1, b);
      chk("R10", "plain blk", b, 0);
    end
    check_mode("R10");

    // R11: idle cycles between steps
    prime('0);
    acc(1'b0, TOP, '0, 1, 1, bl[0]);
    repeat (7) @(posedge clk);
    acc(1'b0, TOP, '0, 1, 1, bl[1]);
    repeat (7) @(posedge clk);
    acc(1'b1, TOP, 8'h00, 1, 0, bl[2]);
    repeat (7) @(posedge clk);
    acc(1'b1, TOP, 8'h07, 1, 0, bl[3]);
    chk("R11", "spaced blk", bl, 4'b1100);
    exp_dens = 2'd3; exp_page = 1'b1;
    check_mode("R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule